// File: doc/BRIEF.md
# Nibble-Addressed BCD Real-Time Clock

This block keeps calendar time as decimal digits, one digit per 4-bit register, across sixteen addresses on a small synchronous bus. Seconds, minutes, hours, day, month, a two-digit year and a weekday advance from an external single-cycle tick that arrives 64 times per second. Software reads and writes the digits one address at a time. It uses a hold bit to stop the visible digits from moving while it assembles a consistent reading. Seconds that fall due during the hold are kept and applied when the hold is released.

A sequencer with four states controls every change to the time digits. **S_IDLE** waits. It moves to **S_STEP** when a second falls due and hold is clear. It moves to **S_WAIT** when a second falls due while hold is set. It moves to **S_TRIM** when a 30-second adjustment is pending and hold is clear; a due second takes priority over a pending adjustment. **S_WAIT** keeps the one pending second and moves to **S_STEP** once hold is clear. **S_STEP** advances the time by one second with full carry. **S_TRIM** performs the 30-second adjustment. Both **S_STEP** and **S_TRIM** last one cycle and return to **S_IDLE**.

The control registers also select 12- or 24-hour counting, stop timekeeping, clear the sub-second divider, and drive a periodic interrupt. The interrupt has a sticky flag and an output that is either a level or a fixed-width pulse, with a mask.

Top module: `rtc_nib_top`

## Requirements
- R1: After reset the digits read 00:00:00, day 01, month 01, year 00, weekday 0. Register 13 reads 0, register 14 reads 0 and register 15 reads 4'b0100 (24-hour mode).
- R2: Addresses 0 to 11 hold the units and then the tens digit of seconds, minutes, hours, day, month and year, in that order. Address 12 holds the weekday. Address 13 is the status/handshake register, 14 the interrupt setup and 15 the mode register. A read strobe presents the addressed value on `rdata_o` one clock later.
- R3: Every 64th qualifying tick raises one second. In 24-hour mode seconds wrap 59→00 into minutes, minutes wrap 59→00 into hours, and hours wrap 23→00 into the day.
- R4: With register 15 bit 2 clear (12-hour mode), hour-tens bits 1:0 hold the tens digit and bit 2 is the PM flag. Hours run 12, 1 … 11. The step from 11 to 12 toggles PM. The step from 11 PM to 12 AM also advances the day, so midnight reads hour-tens 4'b0001 and units 2, and noon reads hour-tens 4'b0101 and units 2.
- R5: The day wraps to 01 after 31, 30 or 28 days according to the month. February has 29 days when the binary year is a multiple of 4. Months run 1 to 12 and the year runs 00 to 99.
- R6: The weekday advances at each day rollover and wraps from 6 to 0.
- R7: While register 13 bit 0 (hold) is set, the time digits do not change except by bus writes. Any number of due seconds during the hold collapse into one pending second, which is applied after the hold is cleared.
- R8: Register 13 bit 1 reads 1 for a read captured in the cycle a step or adjustment is applied, and 0 otherwise.
- R9: Register 15 bit 1 (stop) halts the divider and timekeeping. Register 15 bit 0 clears the divider to zero while set.
- R10: Writing 1 to register 13 bit 3 requests a 30-second adjustment. The adjustment sets the seconds to 00 and, when the seconds were 30 or more, advances the minute with full carry. Bit 3 reads 1 until the adjustment is done, then 0.
- R11: Register 14 bits 3:2 pick the interrupt period: 00 every qualifying tick, 01 every second, 10 every minute rollover, 11 every hour rollover. Each period event sets the flag at register 13 bit 2. Writing register 13 with bit 2 = 0 clears the flag. Writing it with bit 2 = 1 leaves the flag unchanged.
- R12: With register 14 bit 1 = 1, `irq_o` follows the flag. With bit 1 = 0, `irq_o` is high for PULSE_CYC (default 4) cycles after each period event. Register 14 bit 0 = 1 holds `irq_o` low without affecting the flag.
- R13: Writes to register 13 update hold (bit 0) and ignore bit 1. Registers 14 and 15 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Single-cycle 64 Hz timebase pulse |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 4 | Read data, valid one cycle after `rd_i` |
| irq_o | output | 1 | Periodic interrupt or pulse output |

## Verification
The assertions assume that `tick_i` never arrives more often than once every two clocks, so two second events can never fall inside one step. They also assume the weekday register is only ever written with values 0 to 6. The stimulus drives each tick high for one cycle and low for the next, and only ever writes valid weekdays and digits. Random times are drawn with a bias toward the last value of each field, so carries from seconds through to the year, leap Februaries and the 12-hour midnight and noon cases occur often.

// File: rtl/rtc_nib_pkg.sv
package rtc_nib_pkg;

    typedef logic [3:0] nib_t;

    localparam int NUM_TIME = 13;

    localparam nib_t A_SEC_U = 4'd0;
    localparam nib_t A_SEC_T = 4'd1;
    localparam nib_t A_MIN_U = 4'd2;
    localparam nib_t A_MIN_T = 4'd3;
    localparam nib_t A_HR_U  = 4'd4;
    localparam nib_t A_HR_T  = 4'd5;
    localparam nib_t A_DAY_U = 4'd6;
    localparam nib_t A_DAY_T = 4'd7;
    localparam nib_t A_MON_U = 4'd8;
    localparam nib_t A_MON_T = 4'd9;
    localparam nib_t A_YR_U  = 4'd10;
    localparam nib_t A_YR_T  = 4'd11;
    localparam nib_t A_WDAY  = 4'd12;
    localparam nib_t A_STAT  = 4'd13;
    localparam nib_t A_IRQC  = 4'd14;
    localparam nib_t A_MODE  = 4'd15;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_STEP = 2'd1,
        S_WAIT = 2'd2,
        S_TRIM = 2'd3
    } seq_state_t;

    function automatic logic [7:0] dig2bin(input nib_t t, input nib_t u);
        return ({4'b0, t} * 8'd10) + {4'b0, u};
    endfunction

    function automatic nib_t bin_tens(input logic [7:0] v);
        return nib_t'(v / 8'd10);
    endfunction

    function automatic nib_t bin_units(input logic [7:0] v);
        return nib_t'(v % 8'd10);
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'd2:                      return (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_nib_prescale.sv
module rtc_nib_prescale #(
    parameter int TICKS_PER_SEC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic stop_i,
    input  logic clr_i,
    output logic fast_evt_o,
    output logic sec_evt_o
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt;

    always_comb begin
        fast_evt_o = tick_i && !stop_i && !clr_i;
        sec_evt_o  = fast_evt_o && (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt <= '0;
        end else if (fast_evt_o) begin
            cnt <= sec_evt_o ? '0 : cnt + 1'b1;
        end
    end

    AST_STOP_FREEZES_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !clr_i) |=> $stable(cnt)); // R9

endmodule

// File: rtl/rtc_nib_seq.sv
module rtc_nib_seq
    import rtc_nib_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sec_evt_i,
    input  logic hold_i,
    input  logic trim_req_i,
    output logic step_o,
    output logic trim_o,
    output logic busy_o
);
    seq_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (sec_evt_i) begin
                    nxt = hold_i ? S_WAIT : S_STEP;
                end else if (trim_req_i && !hold_i) begin
                    nxt = S_TRIM;
                end
            end
            S_WAIT: begin
                if (!hold_i) begin
                    nxt = S_STEP;
                end
            end
            S_STEP:  nxt = S_IDLE;
            S_TRIM:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        step_o = (state == S_STEP);
        trim_o = (state == S_TRIM);
        busy_o = step_o || trim_o;
    end

    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o); // R8

    AST_STEP_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> !$past(hold_i)); // R7

endmodule

// File: rtl/rtc_nib_time.sv
module rtc_nib_time
    import rtc_nib_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_i,
    input  logic                     trim_i,
    input  logic                     h24_i,
    input  logic                     we_i,
    input  nib_t                     waddr_i,
    input  nib_t                     wdata_i,
    output logic [NUM_TIME-1:0][3:0] regs_o,
    output logic                     min_evt_o,
    output logic                     hour_evt_o
);
    logic [NUM_TIME-1:0][3:0] tr, nx;
    logic [7:0] sec_b, min_b, hr_b, day_b, mon_b, yr_b, dmax;
    logic [7:0] nsec, nmin, nhr, nday, nmon, nyr;
    logic       pm, npm, c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        sec_b = dig2bin(tr[A_SEC_T], tr[A_SEC_U]);
        min_b = dig2bin(tr[A_MIN_T], tr[A_MIN_U]);
        hr_b  = dig2bin({2'b00, tr[A_HR_T][1:0]}, tr[A_HR_U]);
        pm    = tr[A_HR_T][2];
        day_b = dig2bin(tr[A_DAY_T], tr[A_DAY_U]);
        mon_b = dig2bin(tr[A_MON_T], tr[A_MON_U]);
        yr_b  = dig2bin(tr[A_YR_T], tr[A_YR_U]);
        dmax  = month_len(mon_b, yr_b);
    end

    always_comb begin
        nx    = tr;
        nsec  = sec_b;
        nmin  = min_b;
        nhr   = hr_b;
        npm   = pm;
        nday  = day_b;
        nmon  = mon_b;
        nyr   = yr_b;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;

        if (step_i) begin
            if (sec_b >= 8'd59) begin
                nsec  = 8'd0;
                c_min = 1'b1;
            end else begin
                nsec = sec_b + 8'd1;
            end
        end else if (trim_i) begin
            nsec  = 8'd0;
            c_min = (sec_b >= 8'd30);
        end

        if (c_min) begin
            if (min_b >= 8'd59) begin
                nmin = 8'd0;
                c_hr = 1'b1;
            end else begin
                nmin = min_b + 8'd1;
            end
        end

        if (c_hr) begin
            if (h24_i) begin
                if (hr_b >= 8'd23) begin
                    nhr   = 8'd0;
                    c_day = 1'b1;
                end else begin
                    nhr = hr_b + 8'd1;
                end
            end else if (hr_b == 8'd11) begin
                nhr   = 8'd12;
                npm   = !pm;
                c_day = pm;
            end else if (hr_b >= 8'd12) begin
                nhr = 8'd1;
            end else begin
                nhr = hr_b + 8'd1;
            end
        end

        if (c_day) begin
            nx[A_WDAY] = (tr[A_WDAY] >= 4'd6) ? 4'd0 : tr[A_WDAY] + 4'd1;
            if (day_b >= dmax) begin
                nday  = 8'd1;
                c_mon = 1'b1;
            end else begin
                nday = day_b + 8'd1;
            end
        end

        if (c_mon) begin
            if (mon_b >= 8'd12) begin
                nmon = 8'd1;
                c_yr = 1'b1;
            end else begin
                nmon = mon_b + 8'd1;
            end
        end

        if (c_yr) begin
            nyr = (yr_b >= 8'd99) ? 8'd0 : yr_b + 8'd1;
        end

        if (step_i || trim_i) begin
            nx[A_SEC_U] = bin_units(nsec);
            nx[A_SEC_T] = bin_tens(nsec);
            nx[A_MIN_U] = bin_units(nmin);
            nx[A_MIN_T] = bin_tens(nmin);
            nx[A_HR_U]  = bin_units(nhr);
            nx[A_HR_T]  = h24_i ? bin_tens(nhr) : {1'b0, npm, bin_tens(nhr)[1:0]};
            nx[A_DAY_U] = bin_units(nday);
            nx[A_DAY_T] = bin_tens(nday);
            nx[A_MON_U] = bin_units(nmon);
            nx[A_MON_T] = bin_tens(nmon);
            nx[A_YR_U]  = bin_units(nyr);
            nx[A_YR_T]  = bin_tens(nyr);
        end

        if (we_i) begin
            nx[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr          <= '0;
            tr[A_DAY_U] <= 4'd1;
            tr[A_MON_U] <= 4'd1;
        end else begin
            tr <= nx;
        end
    end

    always_comb begin
        regs_o     = tr;
        min_evt_o  = c_min;
        hour_evt_o = c_hr;
    end

    AST_TRIM_ZERO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_i && !(we_i && waddr_i <= A_SEC_T)) |=>
            (tr[A_SEC_U] == 4'd0 && tr[A_SEC_T] == 4'd0)); // R10

    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && tr[A_WDAY] <= 4'd6 && !(we_i && waddr_i == A_WDAY)) |=>
            (tr[A_WDAY] <= 4'd6)); // R6

endmodule

// File: rtl/rtc_nib_irq.sv
module rtc_nib_irq #(
    parameter int PULSE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fast_evt_i,
    input  logic       sec_evt_i,
    input  logic       min_evt_i,
    input  logic       hour_evt_i,
    input  logic [1:0] rate_i,
    input  logic       level_i,
    input  logic       mask_i,
    input  logic       clr_i,
    output logic       flag_o,
    output logic       irq_o
);
    localparam int PW = $clog2(PULSE_CYC + 1);

    logic          period;
    logic [PW-1:0] pcnt;

    always_comb begin
        unique case (rate_i)
            2'b00:   period = fast_evt_i;
            2'b01:   period = sec_evt_i;
            2'b10:   period = min_evt_i;
            default: period = hour_evt_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            pcnt   <= '0;
        end else begin
            if (period) begin
                flag_o <= 1'b1;
            end else if (clr_i) begin
                flag_o <= 1'b0;
            end
            if (period) begin
                pcnt <= PW'(PULSE_CYC);
            end else if (pcnt != '0) begin
                pcnt <= pcnt - 1'b1;
            end
        end
    end

    always_comb begin
        irq_o = !mask_i && (level_i ? flag_o : (pcnt != '0));
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o); // R11

endmodule

// File: rtl/rtc_nib_top.sv
module rtc_nib_top
    import rtc_nib_pkg::*;
#(
    parameter int TICKS_PER_SEC = 64,
    parameter int PULSE_CYC     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [3:0] addr_i,
    input  logic [3:0] wdata_i,
    input  logic       wr_i,
    input  logic       rd_i,
    output logic [3:0] rdata_o,
    output logic       irq_o
);
    logic [NUM_TIME-1:0][3:0] time_regs;
    logic hold, trim_req, flag;
    nib_t irq_cfg, mode_cfg;
    logic fast_evt, sec_evt, step, trim, busy, min_evt, hour_evt;
    logic time_we, stat_we, flag_clr;

    always_comb begin
        time_we  = wr_i && (addr_i <= A_WDAY);
        stat_we  = wr_i && (addr_i == A_STAT);
        flag_clr = stat_we && !wdata_i[2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold     <= 1'b0;
            trim_req <= 1'b0;
            irq_cfg  <= 4'b0000;
            mode_cfg <= 4'b0100;
        end else begin
            if (trim) begin
                trim_req <= 1'b0;
            end
            if (stat_we) begin
                hold <= wdata_i[0];
                if (wdata_i[3]) begin
                    trim_req <= 1'b1;
                end
            end
            if (wr_i && addr_i == A_IRQC) begin
                irq_cfg <= wdata_i;
            end
            if (wr_i && addr_i == A_MODE) begin
                mode_cfg <= wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            unique case (addr_i)
                A_STAT:  rdata_o <= {trim_req, flag, busy, hold};
                A_IRQC:  rdata_o <= irq_cfg;
                A_MODE:  rdata_o <= mode_cfg;
                default: rdata_o <= time_regs[addr_i];
            endcase
        end
    end

    rtc_nib_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .stop_i     (mode_cfg[1]),
        .clr_i      (mode_cfg[0]),
        .fast_evt_o (fast_evt),
        .sec_evt_o  (sec_evt)
    );

    rtc_nib_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_evt_i  (sec_evt),
        .hold_i     (hold),
        .trim_req_i (trim_req),
        .step_o     (step),
        .trim_o     (trim),
        .busy_o     (busy)
    );

    rtc_nib_time u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .trim_i     (trim),
        .h24_i      (mode_cfg[2]),
        .we_i       (time_we),
        .waddr_i    (addr_i),
        .wdata_i    (wdata_i),
        .regs_o     (time_regs),
        .min_evt_o  (min_evt),
        .hour_evt_o (hour_evt)
    );

    rtc_nib_irq #(.PULSE_CYC(PULSE_CYC)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fast_evt_i (fast_evt),
        .sec_evt_i  (sec_evt),
        .min_evt_i  (min_evt),
        .hour_evt_i (hour_evt),
        .rate_i     (irq_cfg[3:2]),
        .level_i    (irq_cfg[1]),
        .mask_i     (irq_cfg[0]),
        .clr_i      (flag_clr),
        .flag_o     (flag),
        .irq_o      (irq_o)
    );

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !busy && !time_we) |=> $stable(time_regs)); // R7

    AST_TRIM_REQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (trim && !(stat_we && wdata_i[3])) |=> !trim_req); // R10

endmodule

// File: tb/rtc_nib_top_bench.sv
module rtc_nib_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] addr = '0;
    logic [3:0] wdata = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [3:0] rdata;
    logic       irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    int m_s, m_mi, m_h, m_d, m_mo, m_y, m_w;

    always #4 clk = !clk;

    rtc_nib_top u_rtc_nib_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .addr_i  (addr),
        .wdata_i (wdata),
        .wr_i    (wr),
        .rd_i    (rd),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [3:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic int dim(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] pk(input int y, mo, d, h, mi, s, w);
        return {8'(y), 8'(mo), 8'(d), 8'(h), 8'(mi), 8'(s), 8'(w)};
    endfunction

    task automatic adv_min();
        if (m_mi == 59) begin
            m_mi = 0;
            if (m_h == 23) begin
                m_h = 0;
                m_w = (m_w == 6) ? 0 : m_w + 1;
                if (m_d == dim(m_mo, m_y)) begin
                    m_d = 1;
                    if (m_mo == 12) begin
                        m_mo = 1;
                        m_y = (m_y == 99) ? 0 : m_y + 1;
                    end else m_mo++;
                end else m_d++;
            end else m_h++;
        end else m_mi++;
    endtask

    task automatic adv_sec();
        if (m_s == 59) begin m_s = 0; adv_min(); end
        else m_s++;
    endtask

    task automatic set_time(input int s, mi, h, d, mo, y, w, input bit h24);
        int h12;
        bit pmf;
        bus_wr(4'd13, 4'b0001);
        bus_wr(4'd15, {1'b0, h24, 2'b01});
        bus_wr(4'd0, 4'(s % 10));  bus_wr(4'd1, 4'(s / 10));
        bus_wr(4'd2, 4'(mi % 10)); bus_wr(4'd3, 4'(mi / 10));
        if (h24) begin
            bus_wr(4'd4, 4'(h % 10)); bus_wr(4'd5, 4'(h / 10));
        end else begin
            pmf = (h >= 12);
            h12 = h % 12;
            if (h12 == 0) h12 = 12;
            bus_wr(4'd4, 4'(h12 % 10)); bus_wr(4'd5, {1'b0, pmf, 2'(h12 / 10)});
        end
        bus_wr(4'd6, 4'(d % 10));  bus_wr(4'd7, 4'(d / 10));
        bus_wr(4'd8, 4'(mo % 10)); bus_wr(4'd9, 4'(mo / 10));
        bus_wr(4'd10, 4'(y % 10)); bus_wr(4'd11, 4'(y / 10));
        bus_wr(4'd12, 4'(w));
        bus_wr(4'd15, {1'b0, h24, 2'b00});
        bus_wr(4'd13, 4'b0000);
        m_s = s; m_mi = mi; m_h = h; m_d = d; m_mo = mo; m_y = y; m_w = w;
    endtask

    task automatic read_time(input bit h24, output logic [55:0] t);
        logic [3:0] r [13];
        int hr, h12;
        for (int i = 0; i < 13; i++) bus_rd(4'(i), r[i]);
        if (h24) hr = r[5][1:0] * 10 + r[4];
        else begin
            h12 = r[5][1:0] * 10 + r[4];
            hr = ((h12 == 12) ? 0 : h12) + (r[5][2] ? 12 : 0);
        end
        t = pk(r[11] * 10 + r[10], r[9] * 10 + r[8], r[7] * 10 + r[6], hr,
               r[3] * 10 + r[2], r[1] * 10 + r[0], r[12]);
    endtask

    function automatic logic [55:0] model_now();
        return pk(m_y, m_mo, m_d, m_h, m_mi, m_s, m_w);
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [3:0]  v;
        logic [55:0] t;
        int          n;
        int          seed_init;
        bit          h24;

        seed_init = $urandom(32'h5EED);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset contents, R2 map layout
        begin
            logic [3:0] rst_exp [16] = '{0,0,0,0,0,0,1,0,1,0,0,0,0,0,0,4'b0100};
            for (int i = 0; i < 16; i++) begin
                bus_rd(4'(i), v);
                chk($sformatf("R1 reset reg %0d", i), 64'(v), 64'(rst_exp[i]));
            end
        end
        bus_wr(4'd12, 4'd5);
        bus_rd(4'd12, v);
        chk("R2 weekday at address 12", 64'(v), 64'd5);
        bus_wr(4'd14, 4'b1001);
        bus_rd(4'd14, v);
        chk("R13 irq setup readback", 64'(v), 64'b1001);
        bus_wr(4'd14, 4'b0000);

        // R3 R5 R6 random times, biased to rollovers
        for (int it = 0; it < 40; it++) begin
            int s, mi, h, d, mo, y, w;
            h24 = 1'($urandom_range(1, 0));
            s   = $urandom_range(1, 0) ? 59 : $urandom_range(58, 0);
            mi  = $urandom_range(1, 0) ? 59 : $urandom_range(58, 0);
            h   = $urandom_range(1, 0) ? (h24 ? 23 : ($urandom_range(1, 0) ? 11 : 23)) : $urandom_range(23, 0);
            mo  = $urandom_range(1, 0) ? ($urandom_range(1, 0) ? 12 : 2) : $urandom_range(12, 1);
            y   = $urandom_range(3, 0) == 0 ? 99 : $urandom_range(99, 0);
            d   = $urandom_range(1, 0) ? dim(mo, y) : $urandom_range(dim(mo, y), 1);
            w   = $urandom_range(6, 0);
            set_time(s, mi, h, d, mo, y, w, h24);
            ticks(64);
            adv_sec();
            read_time(h24, t);
            chk($sformatf("R3 R5 R6 random step %0d h24=%0d", it, h24), 64'(t), 64'(model_now()));
        end

        // R5 leap handling
        set_time(59, 59, 23, 28, 2, 24, 3, 1'b1);
        ticks(64); adv_sec(); read_time(1'b1, t);
        chk("R5 Feb 28 leap year", 64'(t), 64'(pk(24, 2, 29, 0, 0, 0, 4)));
        set_time(59, 59, 23, 28, 2, 23, 3, 1'b1);
        ticks(64); adv_sec(); read_time(1'b1, t);
        chk("R5 Feb 28 common year", 64'(t), 64'(pk(23, 3, 1, 0, 0, 0, 4)));

        // R4 12-hour raw encodings
        set_time(59, 59, 11, 10, 5, 30, 1, 1'b0);
        ticks(64);
        bus_rd(4'd5, v); chk("R4 noon hour tens", 64'(v), 64'b0101);
        bus_rd(4'd4, v); chk("R4 noon hour units", 64'(v), 64'd2);
        set_time(59, 59, 23, 10, 5, 30, 1, 1'b0);
        ticks(64);
        bus_rd(4'd5, v); chk("R4 midnight hour tens", 64'(v), 64'b0001);
        bus_rd(4'd7, v); chk("R4 midnight day tens", 64'(v), 64'd1);
        bus_rd(4'd6, v); chk("R4 midnight day units", 64'(v), 64'd1);
        set_time(59, 59, 0, 10, 5, 30, 1, 1'b0);
        ticks(64);
        bus_rd(4'd4, v); chk("R4 12 AM to 1 AM", 64'(v), 64'd1);

        // R8 busy visible during the step cycle
        set_time(10, 20, 10, 5, 5, 5, 2, 1'b1);
        for (int i = 0; i < 63; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
        @(negedge clk) tick = 1'b1;
        @(negedge clk);
        tick = 1'b0; addr = 4'd13; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        chk("R8 busy during step", 64'(rdata[1]), 64'd1);
        bus_rd(4'd13, v);
        chk("R8 busy clear after step", 64'(v[1]), 64'd0);

        // R7 hold freezes, single pending second
        set_time(30, 20, 10, 5, 5, 5, 2, 1'b1);
        bus_wr(4'd13, 4'b0001);
        ticks(64);
        bus_rd(4'd0, v);
        chk("R7 frozen under hold", 64'(v), 64'd0);
        ticks(64);
        bus_wr(4'd13, 4'b0000);
        repeat (4) @(negedge clk);
        adv_sec();
        read_time(1'b1, t);
        chk("R7 one pending second applied", 64'(t), 64'(model_now()));

        // R9 stop and divider clear
        set_time(30, 20, 10, 5, 5, 5, 2, 1'b1);
        bus_wr(4'd15, 4'b0110);
        ticks(64);
        read_time(1'b1, t);
        chk("R9 stopped", 64'(t), 64'(model_now()));
        bus_wr(4'd15, 4'b0100);
        ticks(40);
        bus_wr(4'd15, 4'b0101);
        bus_wr(4'd15, 4'b0100);
        ticks(63);
        read_time(1'b1, t);
        chk("R9 divider cleared", 64'(t), 64'(model_now()));
        ticks(1);
        adv_sec();
        read_time(1'b1, t);
        chk("R9 counts after clear", 64'(t), 64'(model_now()));

        // R10 thirty-second adjust
        set_time(29, 15, 10, 5, 5, 5, 2, 1'b1);
        bus_wr(4'd13, 4'b1000);
        repeat (4) @(negedge clk);
        read_time(1'b1, t);
        chk("R10 adjust below 30", 64'(t), 64'(pk(5, 5, 5, 10, 15, 0, 2)));
        set_time(45, 59, 23, 31, 12, 99, 6, 1'b1);
        bus_wr(4'd13, 4'b1000);
        repeat (4) @(negedge clk);
        read_time(1'b1, t);
        chk("R10 adjust full carry", 64'(t), 64'(pk(0, 1, 1, 0, 0, 0, 0)));
        bus_rd(4'd13, v);
        chk("R10 adjust bit self-clears", 64'(v[3]), 64'd0);

        // R11 R12 interrupt flag and output
        bus_wr(4'd14, 4'b0010);
        bus_wr(4'd13, 4'b0000);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        chk("R12 level output follows flag", 64'(irq), 64'd1);
        bus_wr(4'd13, 4'b0110);
        bus_rd(4'd13, v);
        chk("R11 write bit2=1 keeps flag", 64'(v[2]), 64'd1);
        chk("R13 status bit1 write ignored", 64'(v[1]), 64'd0);
        bus_wr(4'd13, 4'b0000);
        chk("R11 flag cleared by write", 64'(irq), 64'd0);
        bus_wr(4'd14, 4'b0011);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        chk("R12 mask holds output low", 64'(irq), 64'd0);
        bus_rd(4'd13, v);
        chk("R12 mask keeps flag", 64'(v[2]), 64'd1);
        bus_wr(4'd14, 4'b0000);
        bus_wr(4'd13, 4'b0000);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        n = 0;
        while (irq && n < 20) begin
            n++;
            @(negedge clk);
        end
        chk("R12 pulse width", 64'(n), 64'd4);

        bus_wr(4'd14, 4'b0110);
        set_time(10, 10, 10, 5, 5, 5, 2, 1'b1);
        ticks(63);
        bus_rd(4'd13, v);
        chk("R11 second rate not yet", 64'(v[2]), 64'd0);
        ticks(1);
        bus_rd(4'd13, v);
        chk("R11 second rate fires", 64'(v[2]), 64'd1);

        bus_wr(4'd14, 4'b1010);
        set_time(58, 10, 10, 5, 5, 5, 2, 1'b1);
        ticks(64);
        bus_rd(4'd13, v);
        chk("R11 minute rate not yet", 64'(v[2]), 64'd0);
        ticks(64);
        bus_rd(4'd13, v);
        chk("R11 minute rate fires", 64'(v[2]), 64'd1);

        bus_wr(4'd14, 4'b1110);
        set_time(59, 58, 10, 5, 5, 5, 2, 1'b1);
        ticks(64);
        bus_rd(4'd13, v);
        chk("R11 hour rate ignores minute", 64'(v[2]), 64'd0);
        set_time(59, 59, 10, 5, 5, 5, 2, 1'b1);
        ticks(64);
        bus_rd(4'd13, v);
        chk("R11 hour rate fires", 64'(v[2]), 64'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule